// File: doc/BRIEF.md
# Sixteen-Bit Multi-Cycle Load/Store Processor

This block is a small multi-cycle processor core for a 16-bit load/store instruction set. Each instruction walks through a named-state controller: a three-step fetch, a decode on the top four instruction bits, and then only the phases that this instruction needs. Those phases are address evaluation, operand reads, execute and the write to the destination register. The core has eight general-purpose registers, a program counter, an instruction register, and a memory address and memory data register pair. Every memory transfer, whether for instructions or for data, goes through that pair.

Memory is word-addressed, with 16-bit addresses and 16-bit words. It sits outside the core behind a request/ready handshake, so the core can wait any number of cycles for a slow memory. The core carries out register and immediate arithmetic and logic and bitwise complement. For loads and stores it offers three addressing forms: relative to the program counter, base register plus offset, and indirect through a pointer word. It also provides load-effective-address, a conditional branch on sign flags, and a register jump. A separate flag unit keeps the negative/zero/positive flags. An opcode outside the supported set stops the core and raises a halt output.

Top module: `cpu16_core`

## Requirements
- R1: While reset is high and on the first cycle after it, no memory request is made, halted is low, the program counter holds 0x3000 and the condition flags read zero.
- R2: Fetch takes three steps in this order. The address register loads the program counter while the program counter increments by one. Memory is read into the data register. The instruction register loads from the data register. The first request after reset therefore reads address 0x3000, and an instruction that halts at once returns halted four cycles after reset with a zero-wait memory.
- R3: A request (mem_req high) keeps its address and write flag steady until mem_ready is sampled high. Each wait cycle adds exactly one cycle to the instruction.
- R4: The ADD (opcode 0001) and AND (opcode 0101) instructions write to the register in bits [11:9]. The first operand is the register in bits [8:6]. The second operand is the register in bits [2:0] when bit 5 is 0, and bits [4:0] sign-extended to 16 bits when bit 5 is 1. Addition wraps modulo 2^16.
- R5: NOT (opcode 1001, bits [5:0] all ones) writes the bitwise complement of the register in bits [8:6] to the register in bits [11:9].
- R6: Every register write sets exactly one flag: negative if bit 15 is set, zero if the value is 0, positive otherwise. Stores, branches and jumps leave the flags unchanged.
- R7: LD (0010) and ST (0011) reach the address formed by the incremented program counter plus bits [8:0] sign-extended. Negative offsets are included.
- R8: LDR (0110) and STR (0111) reach the register in bits [8:6] plus bits [5:0] sign-extended. The data register is bits [11:9].
- R9: LDI (1010) and STI (1011) first read a pointer from the PC-relative address, then read or write the operand at that pointer. LDI makes two data reads; STI makes one read and one write.
- R10: LEA (1110) writes the incremented program counter plus the sign-extended bits [8:0] to the register in bits [11:9], with no memory access.
- R11: BR (0000) with condition bits n=[11], z=[10], p=[9] adds the sign-extended bits [8:0] to the incremented program counter when any chosen flag is set. With all three bits clear it never branches; with all three set it always branches.
- R12: JMP (1100) loads the program counter from the register in bits [8:6].
- R13: Opcodes 0100, 1000, 1101 and 1111 set halted. From then on no memory request is made until reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| mem_req | output | 1 | Memory transfer requested |
| mem_we | output | 1 | The requested transfer is a write |
| mem_addr | output | 16 | Word address (memory address register) |
| mem_wdata | output | 16 | Write data (memory data register) |
| mem_rdata | input | 16 | Read data, taken when mem_ready is high |
| mem_ready | input | 1 | Memory completes the pending transfer this cycle |
| halted | output | 1 | Core stopped on an unsupported opcode |

## Verification
Arithmetic vectors are chosen to land on each flag outcome, including signed overflow into bit 15 and carry-out wrapping to zero. The resulting flag is read back through which branch target the core fetches next. A core that set flags from the wrong value or left two flags set would fetch the wrong address. Indirect access is checked by counting reads and by the final write address: a core that skipped the pointer hop would write to the pointer cell. A core that used the raw offset would land elsewhere. The cases that need exact offset arithmetic are negative PC-relative offsets, base-offset stores with offset -1, and branches whose condition bits are all clear or all set. Wait-state runs check that a stalled request holds its address and that the total cycle count grows by exactly one per wait cycle.

// File: rtl/cpu16_pkg.sv
package cpu16_pkg;

    localparam int unsigned WORD_W = 16;
    typedef logic [WORD_W-1:0] word_t;

    // opcode values, taken from instruction bits [15:12]
    localparam logic [3:0] OPC_BR  = 4'b0000;
    localparam logic [3:0] OPC_ADD = 4'b0001;
    localparam logic [3:0] OPC_LD  = 4'b0010;
    localparam logic [3:0] OPC_ST  = 4'b0011;
    localparam logic [3:0] OPC_AND = 4'b0101;
    localparam logic [3:0] OPC_LDR = 4'b0110;
    localparam logic [3:0] OPC_STR = 4'b0111;
    localparam logic [3:0] OPC_NOT = 4'b1001;
    localparam logic [3:0] OPC_LDI = 4'b1010;
    localparam logic [3:0] OPC_STI = 4'b1011;
    localparam logic [3:0] OPC_JMP = 4'b1100;
    localparam logic [3:0] OPC_LEA = 4'b1110;

    typedef enum logic [3:0] {
        ST_FETCH_MAR,
        ST_FETCH_RD,
        ST_FETCH_IR,
        ST_DECODE,
        ST_ADDR,
        ST_MEM_RD,
        ST_PTR,
        ST_ST_DATA,
        ST_MEM_WR,
        ST_EXEC,
        ST_WRITEBACK,
        ST_BRANCH,
        ST_JUMP,
        ST_HALT
    } state_e;

    typedef enum logic [1:0] {
        ALU_ADD,
        ALU_AND,
        ALU_NOT,
        ALU_PASS
    } alu_op_e;

    typedef struct packed {
        logic n;
        logic z;
        logic p;
    } cc_t;

    typedef struct packed {
        logic [3:0] opc;
        logic [2:0] dst;     // destination or store source, also n/z/p mask
        logic [2:0] src1;    // first source or base register
        logic       imm_sel; // bit 5 selects the immediate operand
        logic [4:0] imm5;
        logic [2:0] src2;
        logic [5:0] off6;
        logic [8:0] off9;
    } instr_t;

    function automatic instr_t split_instr(word_t w);
        instr_t d;
        d.opc     = w[15:12];
        d.dst     = w[11:9];
        d.src1    = w[8:6];
        d.imm_sel = w[5];
        d.imm5    = w[4:0];
        d.src2    = w[2:0];
        d.off6    = w[5:0];
        d.off9    = w[8:0];
        return d;
    endfunction

    function automatic word_t sx5(logic [4:0] v);
        return {{(WORD_W-5){v[4]}}, v};
    endfunction

    function automatic word_t sx6(logic [5:0] v);
        return {{(WORD_W-6){v[5]}}, v};
    endfunction

    function automatic word_t sx9(logic [8:0] v);
        return {{(WORD_W-9){v[8]}}, v};
    endfunction

    function automatic logic is_load(logic [3:0] opc);
        return (opc == OPC_LD) || (opc == OPC_LDR) || (opc == OPC_LDI);
    endfunction

    function automatic logic is_store(logic [3:0] opc);
        return (opc == OPC_ST) || (opc == OPC_STR) || (opc == OPC_STI);
    endfunction

    function automatic logic is_indirect(logic [3:0] opc);
        return (opc == OPC_LDI) || (opc == OPC_STI);
    endfunction

endpackage

// File: rtl/cpu16_regfile.sv
module cpu16_regfile #(
    parameter int W  = 16,
    parameter int AW = 3
) (
    input  logic          clk,
    input  logic          rst,
    input  logic [AW-1:0] ra_addr,
    output logic [W-1:0]  ra_data,
    input  logic [AW-1:0] rb_addr,
    output logic [W-1:0]  rb_data,
    input  logic          wr_en,
    input  logic [AW-1:0] wr_addr,
    input  logic [W-1:0]  wr_data
);
    localparam int N = 1 << AW;

    logic [W-1:0] regs [N];
    logic [N-1:0] wsel;

    // one-hot write select per register
    for (genvar i = 0; i < N; i++) begin : g_wsel
        assign wsel[i] = wr_en && (wr_addr == AW'(i));
    end

    always_ff @(posedge clk) begin
        for (int i = 0; i < N; i++) begin
            if (rst) begin
                regs[i] <= '0;
            end else if (wsel[i]) begin
                regs[i] <= wr_data;
            end
        end
    end

    assign ra_data = regs[ra_addr];
    assign rb_data = regs[rb_addr];

endmodule

// File: rtl/cpu16_alu.sv
module cpu16_alu
    import cpu16_pkg::*;
#(
    parameter int W = 16
) (
    input  alu_op_e      op,
    input  logic [W-1:0] a,
    input  logic [W-1:0] b,
    output logic [W-1:0] y
);
    always_comb begin
        unique case (op)
            ALU_ADD: y = a + b;
            ALU_AND: y = a & b;
            ALU_NOT: y = ~a;
            default: y = a;
        endcase
    end
endmodule

// File: rtl/cpu16_flags.sv
module cpu16_flags
    import cpu16_pkg::*;
#(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         upd,
    input  logic [W-1:0] value,
    output cc_t          cc
);
    cc_t cc_d;

    always_comb begin
        cc_d.n = value[W-1];
        cc_d.z = (value == '0);
        cc_d.p = !value[W-1] && (value != '0);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cc <= '{n: 1'b0, z: 1'b1, p: 1'b0};
        end else if (upd) begin
            cc <= cc_d;
        end
    end
endmodule

// File: rtl/cpu16_core.sv
module cpu16_core
    import cpu16_pkg::*;
#(
    parameter logic [15:0] RESET_PC = 16'h3000,
    parameter int          REG_AW   = 3
) (
    input  logic        clk,
    input  logic        rst,
    output logic        mem_req,
    output logic        mem_we,
    output logic [15:0] mem_addr,
    output logic [15:0] mem_wdata,
    input  logic [15:0] mem_rdata,
    input  logic        mem_ready,
    output logic        halted
);
    state_e state_q;
    word_t  pc_q, ir_q, mar_q, mdr_q, temp_q;
    logic   ptr_done_q;

    instr_t  dec;
    word_t   rf_a, rf_b, alu_b, alu_y, ea;
    alu_op_e alu_op;
    logic    rf_we;
    word_t   rf_wdata;
    cc_t     cc;
    logic    take_br;
    logic [REG_AW-1:0] rb_sel;

    assign dec = split_instr(ir_q);

    // store sources come from the destination field, operate sources from [2:0]
    assign rb_sel = is_store(dec.opc) ? dec.dst[REG_AW-1:0] : dec.src2[REG_AW-1:0];

    cpu16_regfile #(.W(WORD_W), .AW(REG_AW)) u_rf (
        .clk     (clk),
        .rst     (rst),
        .ra_addr (dec.src1[REG_AW-1:0]),
        .ra_data (rf_a),
        .rb_addr (rb_sel),
        .rb_data (rf_b),
        .wr_en   (rf_we),
        .wr_addr (dec.dst[REG_AW-1:0]),
        .wr_data (rf_wdata)
    );

    always_comb begin
        unique case (dec.opc)
            OPC_ADD: alu_op = ALU_ADD;
            OPC_AND: alu_op = ALU_AND;
            OPC_NOT: alu_op = ALU_NOT;
            default: alu_op = ALU_PASS;
        endcase
    end

    assign alu_b = dec.imm_sel ? sx5(dec.imm5) : rf_b;

    cpu16_alu #(.W(WORD_W)) u_alu (
        .op (alu_op),
        .a  (rf_a),
        .b  (alu_b),
        .y  (alu_y)
    );

    // effective address: base+offset for LDR/STR, PC-relative otherwise
    always_comb begin
        if ((dec.opc == OPC_LDR) || (dec.opc == OPC_STR)) begin
            ea = rf_a + sx6(dec.off6);
        end else begin
            ea = pc_q + sx9(dec.off9);
        end
    end

    // destination write happens only in the write-back state
    assign rf_we    = (state_q == ST_WRITEBACK);
    assign rf_wdata = is_load(dec.opc) ? mdr_q : temp_q;

    cpu16_flags #(.W(WORD_W)) u_cc (
        .clk   (clk),
        .rst   (rst),
        .upd   (rf_we),
        .value (rf_wdata),
        .cc    (cc)
    );

    assign take_br = (dec.dst[2] && cc.n) || (dec.dst[1] && cc.z) || (dec.dst[0] && cc.p);

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q    <= ST_FETCH_MAR;
            pc_q       <= RESET_PC;
            ir_q       <= '0;
            mar_q      <= '0;
            mdr_q      <= '0;
            temp_q     <= '0;
            ptr_done_q <= 1'b0;
        end else begin
            unique case (state_q)
                ST_FETCH_MAR: begin
                    mar_q      <= pc_q;
                    pc_q       <= pc_q + 16'd1;
                    ptr_done_q <= 1'b0;
                    state_q    <= ST_FETCH_RD;
                end
                ST_FETCH_RD: begin
                    if (mem_ready) begin
                        mdr_q   <= mem_rdata;
                        state_q <= ST_FETCH_IR;
                    end
                end
                ST_FETCH_IR: begin
                    ir_q    <= mdr_q;
                    state_q <= ST_DECODE;
                end
                ST_DECODE: begin
                    unique case (dec.opc)
                        OPC_ADD, OPC_AND, OPC_NOT:            state_q <= ST_EXEC;
                        OPC_LD, OPC_ST, OPC_LDR, OPC_STR,
                        OPC_LDI, OPC_STI, OPC_LEA:            state_q <= ST_ADDR;
                        OPC_BR:                               state_q <= ST_BRANCH;
                        OPC_JMP:                              state_q <= ST_JUMP;
                        default:                              state_q <= ST_HALT;
                    endcase
                end
                ST_ADDR: begin
                    if (dec.opc == OPC_LEA) begin
                        temp_q  <= ea;
                        state_q <= ST_WRITEBACK;
                    end else begin
                        mar_q <= ea;
                        if ((dec.opc == OPC_ST) || (dec.opc == OPC_STR)) begin
                            state_q <= ST_ST_DATA;
                        end else begin
                            state_q <= ST_MEM_RD;
                        end
                    end
                end
                ST_MEM_RD: begin
                    if (mem_ready) begin
                        mdr_q <= mem_rdata;
                        if (is_indirect(dec.opc) && !ptr_done_q) begin
                            state_q <= ST_PTR;
                        end else begin
                            state_q <= ST_WRITEBACK;
                        end
                    end
                end
                ST_PTR: begin
                    mar_q      <= mdr_q;
                    ptr_done_q <= 1'b1;
                    state_q    <= (dec.opc == OPC_STI) ? ST_ST_DATA : ST_MEM_RD;
                end
                ST_ST_DATA: begin
                    mdr_q   <= rf_b;
                    state_q <= ST_MEM_WR;
                end
                ST_MEM_WR: begin
                    if (mem_ready) begin
                        state_q <= ST_FETCH_MAR;
                    end
                end
                ST_EXEC: begin
                    temp_q  <= alu_y;
                    state_q <= ST_WRITEBACK;
                end
                ST_WRITEBACK: begin
                    state_q <= ST_FETCH_MAR;
                end
                ST_BRANCH: begin
                    if (take_br) begin
                        pc_q <= pc_q + sx9(dec.off9);
                    end
                    state_q <= ST_FETCH_MAR;
                end
                ST_JUMP: begin
                    pc_q    <= rf_a;
                    state_q <= ST_FETCH_MAR;
                end
                default: begin
                    state_q <= ST_HALT;
                end
            endcase
        end
    end

    assign mem_req   = (state_q == ST_FETCH_RD) || (state_q == ST_MEM_RD) || (state_q == ST_MEM_WR);
    assign mem_we    = (state_q == ST_MEM_WR);
    assign mem_addr  = mar_q;
    assign mem_wdata = mdr_q;
    assign halted    = (state_q == ST_HALT);

endmodule

// File: rtl/cpu16_checker.sv
module cpu16_checker
    import cpu16_pkg::*;
#(
    parameter logic [15:0] RESET_PC = 16'h3000
) (
    input logic        clk,
    input logic        rst,
    input logic        mem_req,
    input logic        mem_we,
    input logic [15:0] mem_addr,
    input logic        mem_ready,
    input logic        halted,
    input state_e      state,
    input word_t       pc,
    input word_t       mar,
    input word_t       mdr,
    input cc_t         cc
);
    a_r1_out_of_reset: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (pc == RESET_PC && !mem_req && !halted));

    a_r2_fetch_step: assert property (@(posedge clk) disable iff (rst)
        (state == ST_FETCH_MAR) |=> (mar == $past(pc) && pc == $past(pc) + 16'd1));

    a_r3_request_held: assert property (@(posedge clk) disable iff (rst)
        (mem_req && !mem_ready) |=> (mem_req && $stable(mem_addr) && $stable(mem_we)));

    a_r3_write_is_request: assert property (@(posedge clk) disable iff (rst)
        mem_we |-> mem_req);

    a_r6_one_flag: assert property (@(posedge clk) disable iff (rst)
        $countones(cc) == 1);

    a_r9_pointer_hop: assert property (@(posedge clk) disable iff (rst)
        (state == ST_PTR) |=> (mar == $past(mdr)));

    a_r13_halt_quiet: assert property (@(posedge clk) disable iff (rst)
        halted |-> !mem_req);

    a_r13_halt_sticky: assert property (@(posedge clk) disable iff (rst)
        halted |=> halted);
endmodule

bind cpu16_core cpu16_checker #(.RESET_PC(RESET_PC)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .mem_req   (mem_req),
    .mem_we    (mem_we),
    .mem_addr  (mem_addr),
    .mem_ready (mem_ready),
    .halted    (halted),
    .state     (state_q),
    .pc        (pc_q),
    .mar       (mar_q),
    .mdr       (mdr_q),
    .cc        (cc)
);

// File: tb/sim_cpu16_core.sv
`timescale 1ns/1ps
module sim_cpu16_core;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        mem_req, mem_we, halted;
    logic [15:0] mem_addr, mem_wdata;
    logic [15:0] mem_rdata = '0;
    logic        mem_ready = 1'b0;

    always #4 clk = ~clk;

    cpu16_core u0 (
        .clk       (clk),
        .rst       (rst),
        .mem_req   (mem_req),
        .mem_we    (mem_we),
        .mem_addr  (mem_addr),
        .mem_wdata (mem_wdata),
        .mem_rdata (mem_rdata),
        .mem_ready (mem_ready),
        .halted    (halted)
    );

    // memory model: 256 words, indexed by address[7:0]
    logic [15:0] mem [256];
    int          lat = 0;
    int          wcnt = 0;
    int          rd_cnt = 0, wr_cnt = 0;
    logic [15:0] first_rd = '0, last_rd = '0, last_wr = '0;
    int          n_tests = 0, n_fail = 0;
    int          cyc = 0;

    always @(negedge clk) begin
        if (rst) begin
            mem_ready = 1'b0;
            wcnt      = 0;
        end else if (mem_ready) begin
            mem_ready = 1'b0;
        end else if (mem_req) begin
            if (wcnt >= lat) begin
                wcnt      = 0;
                mem_ready = 1'b1;
                if (mem_we) begin
                    mem[mem_addr[7:0]] = mem_wdata;
                    wr_cnt  = wr_cnt + 1;
                    last_wr = mem_addr;
                end else begin
                    mem_rdata = mem[mem_addr[7:0]];
                    if (rd_cnt == 0) first_rd = mem_addr;
                    rd_cnt  = rd_cnt + 1;
                    last_rd = mem_addr;
                end
            end else begin
                wcnt = wcnt + 1;
            end
        end
    end

    localparam logic [15:0] HLT = 16'hD000;

    typedef struct packed {
        logic [2:0]  kind;   // 0 add, 1 and, 2 not, 3 add-imm, 4 and-imm
        logic [15:0] a;
        logic [15:0] b;
        logic [4:0]  imm;
        logic [2:0]  wait_n;
        logic [15:0] exp;
    } vec_t;

    localparam int NV = 10;
    localparam vec_t VECS [NV] = '{
        '{3'd0, 16'h0005, 16'h0003, 5'h00, 3'd0, 16'h0008},
        '{3'd0, 16'h7FFF, 16'h0001, 5'h00, 3'd1, 16'h8000},
        '{3'd0, 16'hFFFF, 16'h0001, 5'h00, 3'd2, 16'h0000},
        '{3'd1, 16'hF0F0, 16'h0FF0, 5'h00, 3'd0, 16'h00F0},
        '{3'd1, 16'hAAAA, 16'h5555, 5'h00, 3'd3, 16'h0000},
        '{3'd2, 16'h00FF, 16'h1234, 5'h00, 3'd1, 16'hFF00},
        '{3'd3, 16'h0010, 16'h0000, 5'h1D, 3'd0, 16'h000D},
        '{3'd3, 16'h0001, 16'h7777, 5'h1F, 3'd2, 16'h0000},
        '{3'd4, 16'h8123, 16'h0000, 5'h10, 3'd0, 16'h8120},
        '{3'd4, 16'h1234, 16'h0000, 5'h0F, 3'd1, 16'h0004}
    };

    task automatic check(input string tag, input logic [15:0] act, input logic [15:0] exp);
        n_tests = n_tests + 1;
        if (act !== exp) begin
            n_fail = n_fail + 1;
            $display("FAIL %s actual=0x%04h expected=0x%04h", tag, act, exp);
        end
    endtask

    task automatic clear_mem();
        for (int i = 0; i < 256; i++) mem[i] = HLT;
    endtask

    task automatic run_prog(input int l);
        lat = l;
        rst = 1'b1;
        repeat (2) @(negedge clk);
        rd_cnt = 0; wr_cnt = 0; first_rd = '0; last_rd = '0; last_wr = '0;
        rst = 1'b0;
        cyc = 0;
        while (1) begin
            @(posedge clk);
            cyc = cyc + 1;
            @(negedge clk);
            if (halted) break;
            if (cyc > 3000) begin
                check("run timeout", 16'(cyc), 16'd0);
                break;
            end
        end
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_tests = n_tests + 1;
        n_fail  = n_fail + 1;
        $display("FAIL watchdog expired");
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        logic [15:0] op_word;
        logic [15:0] flag_addr;
        clear_mem();

        // R1: state while in reset
        repeat (3) @(negedge clk);
        check("R1 no request in reset", {15'd0, mem_req}, 16'd0);
        check("R1 halted low in reset", {15'd0, halted}, 16'd0);

        // R1/R2/R13: a single halting word
        clear_mem();
        run_prog(0);
        check("R2 first fetch address", first_rd, 16'h3000);
        check("R2 cycles to halt, no wait", 16'(cyc), 16'd4);
        check("R13 halted raised", {15'd0, halted}, 16'd1);
        // R3: wait states stretch the fetch one cycle each
        run_prog(3);
        check("R3 cycles to halt, three waits", 16'(cyc), 16'd7);

        // vector table: R4 R5 results, R6 flags via branch target
        for (int v = 0; v < NV; v++) begin
            clear_mem();
            mem[8'h80] = VECS[v].a;
            mem[8'h81] = VECS[v].b;
            unique case (VECS[v].kind)
                3'd0:    op_word = {4'b0001, 3'd3, 3'd1, 3'b000, 3'd2};
                3'd1:    op_word = {4'b0101, 3'd3, 3'd1, 3'b000, 3'd2};
                3'd2:    op_word = {4'b1001, 3'd3, 3'd1, 6'h3F};
                3'd3:    op_word = {4'b0001, 3'd3, 3'd1, 1'b1, VECS[v].imm};
                default: op_word = {4'b0101, 3'd3, 3'd1, 1'b1, VECS[v].imm};
            endcase
            mem[0] = {4'b0010, 3'd1, 9'h07F};       // LD R1, data a
            mem[1] = {4'b0010, 3'd2, 9'h07F};       // LD R2, data b
            mem[2] = op_word;
            mem[3] = {4'b0011, 3'd3, 9'h07E};       // ST R3 -> 0x3082
            mem[4] = {4'b0000, 3'b100, 9'h00B};     // n -> 0x3010
            mem[5] = {4'b0000, 3'b010, 9'h00B};     // z -> 0x3011
            mem[6] = {4'b0000, 3'b001, 9'h00B};     // p -> 0x3012
            run_prog(int'(VECS[v].wait_n));
            check((VECS[v].kind == 3'd2) ? "R5 complement result" : "R4 operate result",
                  mem[8'h82], VECS[v].exp);
            flag_addr = VECS[v].exp[15] ? 16'h3010 : (VECS[v].exp == 16'h0 ? 16'h3011 : 16'h3012);
            check("R6 flag selects branch target", last_rd, flag_addr);
        end

        // R8 base+offset, R10 load effective address
        clear_mem();
        mem[8'h82] = 16'hBEEF;
        mem[0] = {4'b1110, 3'd1, 9'h07F};                 // LEA R1 -> 0x3080
        mem[1] = {4'b0110, 3'd2, 3'd1, 6'd2};             // LDR R2, R1, #2
        mem[2] = {4'b0111, 3'd2, 3'd1, 6'h3F};            // STR R2, R1, #-1
        mem[3] = {4'b0111, 3'd1, 3'd1, 6'd3};             // STR R1, R1, #3
        run_prog(1);
        check("R8 base+offset store at -1", mem[8'h7F], 16'hBEEF);
        check("R10 address written by LEA", mem[8'h83], 16'h3080);
        check("R10 LEA makes no memory read", 16'(rd_cnt), 16'd6);

        // R9 indirect load then indirect store
        clear_mem();
        mem[8'h80] = 16'h3090;
        mem[8'h90] = 16'h1357;
        mem[8'h81] = 16'h30A0;
        mem[0] = {4'b1010, 3'd5, 9'h07F};                 // LDI R5
        mem[1] = {4'b1011, 3'd5, 9'h07F};                 // STI R5
        run_prog(2);
        check("R9 indirect data moved", mem[8'hA0], 16'h1357);
        check("R9 write goes to pointer target", last_wr, 16'h30A0);
        check("R9 read count with two pointer hops", 16'(rd_cnt), 16'd6);
        check("R9 single write", 16'(wr_cnt), 16'd1);

        // R7 negative PC-relative offset
        clear_mem();
        mem[8'hF0] = 16'h4242;
        mem[0] = {4'b0010, 3'd1, 9'h1EF};                 // LD R1 <- 0x2FF0
        mem[1] = {4'b0011, 3'd1, 9'h07E};                 // ST R1 -> 0x3080
        run_prog(2);
        check("R7 negative offset load", mem[8'h80], 16'h4242);
        check("R7 store address", last_wr, 16'h3080);

        // R12 register jump
        clear_mem();
        mem[0] = {4'b1110, 3'd7, 9'd4};                   // LEA R7 -> 0x3005
        mem[1] = {4'b1100, 3'd0, 3'd7, 6'd0};             // JMP R7
        mem[2] = 16'h1DE0;                                // would corrupt nothing; skipped
        run_prog(0);
        check("R12 jump target fetched", last_rd, 16'h3005);
        check("R12 fetch count", 16'(rd_cnt), 16'd3);

        // R11 empty mask never branches, full mask always does
        clear_mem();
        mem[0] = {4'b0101, 3'd0, 3'd0, 1'b1, 5'd0};       // AND R0, R0, #0 -> z
        mem[1] = {4'b0000, 3'b000, 9'd5};                 // never
        mem[2] = {4'b0000, 3'b101, 9'd5};                 // n or p: not taken
        mem[3] = {4'b0000, 3'b111, 9'd2};                 // always -> 0x3006
        run_prog(1);
        check("R11 branch masks", last_rd, 16'h3006);

        // R13 each unsupported opcode halts and stays quiet
        foreach (VECS[k]) begin
            if (k < 4) begin
                logic [3:0] bad;
                bad = (k == 0) ? 4'b0100 : (k == 1) ? 4'b1000 : (k == 2) ? 4'b1101 : 4'b1111;
                clear_mem();
                mem[0] = {bad, 12'h000};
                run_prog(0);
                repeat (10) @(negedge clk);
                check("R13 halted stays high", {15'd0, halted}, 16'd1);
                check("R13 no access after halt", 16'(rd_cnt + wr_cnt), 16'd1);
            end
        end

        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule